// File: doc/BRIEF.md
# Upper-Immediate and Unsigned-Compare Execute Unit

This block is a single-cycle execute stage for a 32-bit integer core that covers three instruction forms: load-upper-immediate, add-upper-immediate-to-PC and set-if-less-than-unsigned with an immediate operand. Each cycle it accepts an instruction word, the address of that instruction and the value of its first source register. In the same cycle it produces the destination index, a write strobe, the result and the address of the next instruction. The result is committed on the next rising clock edge to an internal bank of 32 registers, which can be inspected through a combinational read port.

After reset, registers 1 to 31 hold a recognisable fill word. Register 0 is wired to zero. An instruction whose major opcode is not one of the three handled forms raises an illegal indication for the cycle it is presented. Such an instruction writes nothing, and the next PC still advances by one instruction.

Top module: `imx_exec_unit`

## Requirements
- R1: Opcode 0110111 (bits [6:0]) writes {insn[31:12], 12'h000} to the register named by bits [11:7].
- R2: Opcode 0010111 writes pc + {insn[31:12], 12'h000} to rd, with the sum taken modulo 2^32.
- R3: Opcode 0010011 with bits [14:12] = 011 writes 1 when rs1_val is below the 12-bit immediate from bits [31:20] sign-extended to 32 bits, and 0 otherwise. Both operands are compared as unsigned numbers.
- R4: For every valid instruction, recognised or not, pc_next equals pc + 4 modulo 2^32.
- R5: After reset, registers 1 to 31 read 32'hF0F0F0F0 and register 0 reads 0.
- R6: A valid recognised instruction with a non-zero rd sets wb_en and presents wb_idx = insn[11:7]. After the next rising edge, the read port returns the written value for that index, and every other register is left unchanged.
- R7: When rd is 0, wb_en stays low and register 0 still reads 0.
- R8: Any other opcode, including 0010011 with a bits [14:12] value other than 011, raises illegal for that cycle, keeps wb_en low and leaves every register unchanged.
- R9: While insn_valid is low, wb_en and illegal are both low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word present this cycle |
| insn | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| rs1_val | input | 32 | Value of the first source register |
| rf_raddr | input | 5 | Inspection read index |
| rf_rdata | output | 32 | Register contents at rf_raddr |
| wb_en | output | 1 | Result will be written this cycle |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Result value |
| pc_next | output | 32 | Address of the following instruction |
| illegal | output | 1 | Unrecognised opcode presented |

## Verification
On every cycle, the assertions check these properties: the write strobe and the illegal flag never rise together, no write ever targets index 0, and an idle cycle produces neither. They also check that the compare result is a single bit, that a load-upper result has a zero low field and that the next PC is one instruction ahead. In the register bank, they confirm that a write lands on the following edge and that the bank holds still when no write is strobed. The actual arithmetic values need the bench's directed scenarios to show them. These include the wrapping PC sum, the sign-extended immediate that flips the unsigned compare, and the reset fill pattern.

// File: rtl/imx_pkg.sv
package imx_pkg;
   localparam logic [6:0] OPC_LDUP  = 7'b0110111;
   localparam logic [6:0] OPC_ADDUP = 7'b0010111;
   localparam logic [6:0] OPC_IMMOP = 7'b0010011;
   localparam logic [2:0] F3_CMPU   = 3'b011;

   typedef enum logic [1:0] {
      K_NONE  = 2'd0,
      K_LDUP  = 2'd1,
      K_ADDUP = 2'd2,
      K_CMPU  = 2'd3
   } insn_kind_e;

   typedef struct packed {
      insn_kind_e kind;
      logic       bad;
      logic [4:0] rd;
      logic [4:0] rs1;
      logic [19:0] upper;
      logic [11:0] imm12;
   } dec_t;
endpackage

// File: rtl/imx_decode.sv
module imx_decode
   import imx_pkg::*;
#(
   parameter int ILEN = 32
) (
   input  logic            valid,
   input  logic [ILEN-1:0] word,
   output dec_t            dec
);
   generate
      if (ILEN != 32) begin : g_bad_ilen
         $error("imx_decode: ILEN must be 32");
      end
   endgenerate

   logic [6:0] opc;
   logic [2:0] f3;

   always_comb begin
      opc       = word[6:0];
      f3        = word[14:12];
      dec.rd    = word[11:7];
      dec.rs1   = word[19:15];
      dec.upper = word[31:12];
      dec.imm12 = word[31:20];
      dec.kind  = K_NONE;
      dec.bad   = 1'b0;
      if (valid) begin
         if (opc == OPC_LDUP)                          dec.kind = K_LDUP;
         else if (opc == OPC_ADDUP)                    dec.kind = K_ADDUP;
         else if (opc == OPC_IMMOP && f3 == F3_CMPU)   dec.kind = K_CMPU;
         else                                          dec.bad  = 1'b1;
      end
   end
endmodule

// File: rtl/imx_alu.sv
module imx_alu
   import imx_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          PC_STEP   = 4,
   parameter bit          CMP_BY_SUB = 1'b1
) (
   input  dec_t            dec,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] rs1_val,
   output logic [XLEN-1:0] result,
   output logic [XLEN-1:0] pc_next
);
   localparam int LOWZ = 12;
   localparam int UPW  = XLEN - LOWZ;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("imx_alu: XLEN must be 32");
      end
      if (PC_STEP <= 0) begin : g_bad_step
         $error("imx_alu: PC_STEP must be positive");
      end
   endgenerate

   logic [XLEN-1:0] up_val;
   logic [XLEN-1:0] sx_imm;
   logic            below;

   assign up_val = {dec.upper[UPW-1:0], {LOWZ{1'b0}}};
   assign sx_imm = {{(XLEN-12){dec.imm12[11]}}, dec.imm12};

   generate
      if (CMP_BY_SUB) begin : g_cmp_sub
         logic [XLEN:0] diff;
         assign diff  = {1'b0, rs1_val} - {1'b0, sx_imm};
         assign below = diff[XLEN];
      end else begin : g_cmp_rel
         assign below = (rs1_val < sx_imm);
      end
   endgenerate

   always_comb begin
      unique case (dec.kind)
         K_LDUP:  result = up_val;
         K_ADDUP: result = pc + up_val;
         K_CMPU:  result = {{(XLEN-1){1'b0}}, below};
         default: result = '0;
      endcase
   end

   assign pc_next = pc + XLEN'(PC_STEP);
endmodule

// File: rtl/imx_regbank.sv
module imx_regbank #(
   parameter int              XLEN  = 32,
   parameter int              NREGS = 32,
   parameter logic [XLEN-1:0] FILL  = 32'hF0F0F0F0,
   localparam int             IDXW  = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IDXW-1:0] waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [IDXW-1:0] raddr,
   output logic [XLEN-1:0] rdata
);
   generate
      if (NREGS < 2 || (1 << IDXW) != NREGS) begin : g_bad_n
         $error("imx_regbank: NREGS must be a power of two, at least 2");
      end
   endgenerate

   logic [NREGS*XLEN-1:0] flat;

   generate
      for (genvar g = 0; g < NREGS; g++) begin : g_reg
         if (g == 0) begin : g_zero
            assign flat[0 +: XLEN] = '0;
         end else begin : g_store
            logic [XLEN-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                          q <= FILL;
               else if (we && waddr == IDXW'(g))    q <= wdata;
            end
            assign flat[g*XLEN +: XLEN] = q;
         end
      end
   endgenerate

   assign rdata = flat[raddr*XLEN +: XLEN];

   function automatic logic [XLEN-1:0] word_at(input logic [IDXW-1:0] i);
      return flat[i*XLEN +: XLEN];
   endfunction

   // R6: a strobed write to a non-zero index is visible after the edge
   p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr != '0) |=> word_at($past(waddr)) == $past(wdata));
   // R8/R9: no strobe, no change anywhere in the bank
   p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(flat));
endmodule

// File: rtl/imx_exec_unit.sv
module imx_exec_unit
   import imx_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          NREGS      = 32,
   parameter int          PC_STEP    = 4,
   parameter logic [31:0] FILL       = 32'hF0F0F0F0,
   parameter bit          CMP_BY_SUB = 1'b1,
   localparam int         IDXW       = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            insn_valid,
   input  logic [31:0]     insn,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [IDXW-1:0] rf_raddr,
   output logic [XLEN-1:0] rf_rdata,
   output logic            wb_en,
   output logic [IDXW-1:0] wb_idx,
   output logic [XLEN-1:0] wb_data,
   output logic [XLEN-1:0] pc_next,
   output logic            illegal
);
   generate
      if (NREGS != 32) begin : g_bad_regs
         $error("imx_exec_unit: the 5-bit rd field needs NREGS of 32");
      end
   endgenerate

   dec_t dec;

   imx_decode #(.ILEN(32)) u_dec (
      .valid (insn_valid),
      .word  (insn),
      .dec   (dec)
   );

   imx_alu #(.XLEN(XLEN), .PC_STEP(PC_STEP), .CMP_BY_SUB(CMP_BY_SUB)) u_alu (
      .dec     (dec),
      .pc      (pc),
      .rs1_val (rs1_val),
      .result  (wb_data),
      .pc_next (pc_next)
   );

   assign wb_idx  = dec.rd[IDXW-1:0];
   assign wb_en   = (dec.kind != K_NONE) && (dec.rd != 5'd0);
   assign illegal = dec.bad;

   imx_regbank #(.XLEN(XLEN), .NREGS(NREGS), .FILL(FILL[XLEN-1:0])) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wb_en),
      .waddr (wb_idx),
      .wdata (wb_data),
      .raddr (rf_raddr),
      .rdata (rf_rdata)
   );

   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_en && illegal));
   p_no_x0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> wb_idx != '0);
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |-> (!wb_en && !illegal));
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid |-> pc_next == pc + XLEN'(4));
   p_bool_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && insn[6:0] == 7'b0010011) |-> wb_data[XLEN-1:1] == '0);
   p_lowzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && insn[6:0] == 7'b0110111) |-> wb_data[11:0] == 12'h000);
endmodule

// File: tb/tb_imx_exec_unit.sv
module tb_imx_exec_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [31:0] insn = '0;
   logic [31:0] pc = '0;
   logic [31:0] rs1_val = '0;
   logic [4:0]  rf_raddr = '0;
   logic [31:0] rf_rdata;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [31:0] wb_data;
   logic [31:0] pc_next;
   logic        illegal;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   imx_exec_unit dut (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
      .pc(pc), .rs1_val(rs1_val), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
      .pc_next(pc_next), .illegal(illegal)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // present one instruction after a falling edge, sample outputs mid-phase
   task automatic present(input logic [31:0] w, input logic [31:0] p, input logic [31:0] r1);
      @(negedge clk);
      insn_valid = 1'b1; insn = w; pc = p; rs1_val = r1;
      #2;
   endtask

   // let the edge commit, then go idle and peek at a register
   task automatic commit_and_read(input logic [4:0] idx, output logic [31:0] val);
      @(posedge clk);
      #1;
      insn_valid = 1'b0;
      rf_raddr = idx;
      #1;
      val = rf_rdata;
   endtask

   function automatic logic [31:0] cmpu_word(input logic [11:0] imm, input logic [4:0] rd);
      return {imm, 5'd1, 3'b011, rd, 7'b0010011};
   endfunction

   task automatic t_reset;
      rf_raddr = 5'd0; #1;
      chk("R5 x0 after reset", rf_rdata, 32'h0);
      for (int i = 1; i < 32; i++) begin
         rf_raddr = 5'(i); #1;
         chk("R5 fill after reset", rf_rdata, 32'hF0F0F0F0);
      end
      chk("R9 idle wb_en", {31'b0, wb_en}, 32'd0);
      chk("R9 idle illegal", {31'b0, illegal}, 32'd0);
   endtask

   task automatic t_ldup;
      logic [31:0] v;
      present(32'h000032B7, 32'h00010074, 32'h0);
      chk("R1 wb_data small", wb_data, 32'h00003000);
      chk("R6 wb_en", {31'b0, wb_en}, 32'd1);
      chk("R6 wb_idx", {27'b0, wb_idx}, 32'd5);
      chk("R4 pc_next", pc_next, 32'h00010078);
      commit_and_read(5'd5, v);
      chk("R6 x5 after write", v, 32'h00003000);
      present(32'hFFFFF2B7, 32'h00010078, 32'h0);
      chk("R1 wb_data all-ones upper", wb_data, 32'hFFFFF000);
      commit_and_read(5'd5, v);
      chk("R1 x5 after write", v, 32'hFFFFF000);
      present(32'hABCDEFB7, 32'h00010000, 32'h0);
      commit_and_read(5'd31, v);
      chk("R6 x31 written", v, 32'hABCDE000);
      rf_raddr = 5'd6; #1;
      chk("R6 neighbour x6 unchanged", rf_rdata, 32'hF0F0F0F0);
   endtask

   task automatic t_addup;
      logic [31:0] v;
      present(32'h00003297, 32'h0001007C, 32'h0);
      chk("R2 pc-relative sum", wb_data, 32'h0001307C);
      chk("R4 pc_next", pc_next, 32'h00010080);
      commit_and_read(5'd5, v);
      chk("R2 x5 after write", v, 32'h0001307C);
      present(32'h81000297, 32'h00010080, 32'h0);
      chk("R2 high immediate", wb_data, 32'h81010080);
      present(32'hFFFFF297, 32'h00002000, 32'h0);
      chk("R2 wrap modulo 2^32", wb_data, 32'h00001000);
      present(32'h00000297, 32'hFFFFFFFC, 32'h0);
      chk("R4 pc_next wraps", pc_next, 32'h00000000);
      commit_and_read(5'd5, v);
   endtask

   task automatic t_cmpu;
      logic [31:0] v;
      present(cmpu_word(12'hFFF, 5'd7), 32'h100, 32'd5);
      chk("R3 imm FFF is max unsigned", wb_data, 32'd1);
      commit_and_read(5'd7, v);
      chk("R3 x7 after write", v, 32'd1);
      present(cmpu_word(12'hFFF, 5'd7), 32'h104, 32'hFFFFFFFF);
      chk("R3 equal max gives 0", wb_data, 32'd0);
      present(cmpu_word(12'd10, 5'd7), 32'h108, 32'd10);
      chk("R3 equal gives 0", wb_data, 32'd0);
      present(cmpu_word(12'd10, 5'd7), 32'h10C, 32'd9);
      chk("R3 one below gives 1", wb_data, 32'd1);
      present(cmpu_word(12'h800, 5'd7), 32'h110, 32'h00000800);
      chk("R3 sign-extended 800 above rs1", wb_data, 32'd1);
      present(cmpu_word(12'h7FF, 5'd7), 32'h114, 32'h00000800);
      chk("R3 positive imm below rs1", wb_data, 32'd0);
      chk("R4 pc_next", pc_next, 32'h118);
      commit_and_read(5'd7, v);
      chk("R3 x7 cleared", v, 32'd0);
   endtask

   task automatic t_rd_zero;
      logic [31:0] v;
      present(32'h00003037, 32'h200, 32'h0);
      chk("R7 no strobe for rd 0", {31'b0, wb_en}, 32'd0);
      chk("R7 not illegal", {31'b0, illegal}, 32'd0);
      commit_and_read(5'd0, v);
      chk("R7 x0 still zero", v, 32'h0);
   endtask

   task automatic t_illegal;
      logic [31:0] v;
      present(32'h00B50433, 32'h300, 32'h0);
      chk("R8 illegal raised", {31'b0, illegal}, 32'd1);
      chk("R8 no strobe", {31'b0, wb_en}, 32'd0);
      chk("R4 pc_next on illegal", pc_next, 32'h304);
      commit_and_read(5'd8, v);
      chk("R8 x8 unchanged", v, 32'hF0F0F0F0);
      chk("R8 illegal drops when idle", {31'b0, illegal}, 32'd0);
      present({12'd1, 5'd1, 3'b000, 5'd9, 7'b0010011}, 32'h304, 32'h0);
      chk("R8 other funct3 illegal", {31'b0, illegal}, 32'd1);
      commit_and_read(5'd9, v);
      chk("R8 x9 unchanged", v, 32'hF0F0F0F0);
   endtask

   task automatic t_idle;
      logic [31:0] v;
      @(negedge clk);
      insn_valid = 1'b0; insn = 32'h12345537; pc = 32'h400;
      #2;
      chk("R9 no strobe when invalid", {31'b0, wb_en}, 32'd0);
      chk("R9 no illegal when invalid", {31'b0, illegal}, 32'd0);
      @(posedge clk); #1;
      rf_raddr = 5'd10; #1;
      v = rf_rdata;
      chk("R9 x10 unchanged", v, 32'hF0F0F0F0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_ldup();
      t_addup();
      t_cmpu();
      t_rd_zero();
      t_illegal();
      t_idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      total++;
      bad++;
      $display("FAIL watchdog R1-chain actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule